// File: doc/BRIEF.md
# I2C Slave Byte Engine with Holding Registers

This block is the target side of a two-wire serial bus. It samples the clock and data lines through synchronizers and watches for start, repeated start and stop conditions. It compares each address byte with a 7-bit own address. After a match it either receives bytes or sends them, moving each byte through an internal shift register. It never drives a line high. It pulls data low through an open-drain enable, `sda_oe`, where 1 means drive low.

A CPU writes outgoing bytes into a transmit holding register and reads incoming bytes from a receive holding register, using single-cycle strobes. Four flags report the state of the transfer:
- the transfer direction,
- the acknowledge the master returned,
- transmit-holding-empty,
- receive-holding-full.

Outgoing data moves from the holding register into the shifter in only two cases: after an address match with a read request, and after the master acknowledges the previous byte. A refusal from the master leaves the holding register untouched and frees the data line.

Top module: `i2c_slave_engine`

## Requirements
- R1: Both bus inputs pass through two-flop synchronizers. SDA falling while SCL is high is a start, and it begins address reception in any state, including in the middle of a transfer (repeated start). SDA rising while SCL is high is a stop. A stop returns the engine to idle with SDA released, and bits clocked after it are ignored until the next start.
- R2: The address byte is received MSB first: seven address bits, then a direction bit. On a match with `own_addr` the engine pulls SDA low during the 9th clock. On a mismatch it gives no acknowledge and ignores the bus until the next start.
- R3: `dir_rd` updates only when an address matches. It is 1 for a master read (bit 0 of the address byte = 1) and 0 for a master write. It resets to 0.
- R4: In receive mode each data byte is shifted in MSB first and acknowledged during the 9th clock. When the 8th bit completes, the byte is copied to `rx_data`.
- R5: `rx_full` sets when a byte is copied to `rx_data`. It clears on an `rd_rx` strobe and resets to 0.
- R6: A `wr_tx` strobe stores `wr_data` in the transmit holding register and clears `tx_empty`. The holding register resets to 0xFF.
- R7: The holding register is copied into the shifter after a matched read address and after each byte that the master acknowledged. The copy sets `tx_empty`. Bits go out MSB first, and a 0 bit is sent by pulling SDA low.
- R8: `rxnak` captures SDA at the 9th clock of each transmitted byte: 0 means acknowledge, 1 means no acknowledge. It resets to 1. After a no-acknowledge the engine releases SDA, does not load the holding register, leaves `tx_empty` unchanged and waits for a start or stop.
- R9: SDA starts being pulled low only while SCL is low.
- R10: While `en` is 0 the engine stays idle, releases SDA, ignores the bus and `wr_tx`, and holds every flag and the holding register at its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable |
| own_addr | input | 7 | Own bus address |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| wr_tx | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_rx | input | 1 | Read strobe for the receive holding register |
| rx_data | output | 8 | Last received byte |
| dir_rd | output | 1 | 1 when the master reads |
| rxnak | output | 1 | Master's acknowledge bit from the last sent byte |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_full | output | 1 | Receive holding register full |

## Verification
The assertions assume that the master never issues a start or stop while the engine holds SDA low. They also assume that every SCL phase lasts many system clocks, so the synchronizer delay ends before the next edge. The bench's master tasks keep SCL low and high for ten or more clocks at each step. They change SDA only while SCL is low, except for deliberate start and stop conditions, and they issue those only after the engine has released the line.

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] own_addr,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          wr_tx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_rx,
  output logic [DW-1:0] rx_data,
  output logic          dir_rd,
  output logic          rxnak,
  output logic          tx_empty,
  output logic          rx_full
);
  localparam int AB = AW + 1;
  localparam int CW = $clog2(DW + 2);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK} st_t;

  st_t st;
  logic [1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sr, tsr, txh;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start = scl_s & scl_d & sda_d & ~sda_s;
  wire stop = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_d <= 1'b1; sda_d <= 1'b1;
      st <= S_IDLE; cnt <= '0; sr <= '0; tsr <= '1; txh <= '1;
      rx_data <= '0; sda_oe <= 1'b0; dir_rd <= 1'b0; rxnak <= 1'b1;
      tx_empty <= 1'b1; rx_full <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
      if (!en) begin
        st <= S_IDLE; cnt <= '0; txh <= '1; sda_oe <= 1'b0; dir_rd <= 1'b0;
        rxnak <= 1'b1; tx_empty <= 1'b1; rx_full <= 1'b0;
      end else begin
        if (rd_rx) rx_full <= 1'b0;
        if (stop) begin
          st <= S_IDLE; sda_oe <= 1'b0;
        end else if (start) begin
          st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
        end else begin
          case (st)
            S_ADDR: begin
              if (scl_rise) begin
                sr <= {sr[DW-2:0], sda_s}; cnt <= cnt + 1'b1;
              end else if (scl_fall && cnt == CW'(AB)) begin
                if (sr[AW:1] == own_addr) begin
                  dir_rd <= sr[0]; sda_oe <= 1'b1; st <= S_AACK;
                end else st <= S_IDLE;
              end
            end
            S_AACK: if (scl_fall) begin
              cnt <= '0;
              if (dir_rd) begin
                tsr <= txh; tx_empty <= 1'b1; sda_oe <= ~txh[DW-1]; st <= S_TX;
              end else begin
                sda_oe <= 1'b0; st <= S_RX;
              end
            end
            S_RX: begin
              if (scl_rise) begin
                sr <= {sr[DW-2:0], sda_s}; cnt <= cnt + 1'b1;
              end else if (scl_fall && cnt == CW'(DW)) begin
                rx_data <= sr; rx_full <= 1'b1; sda_oe <= 1'b1; st <= S_RACK;
              end
            end
            S_RACK: if (scl_fall) begin
              sda_oe <= 1'b0; cnt <= '0; st <= S_RX;
            end
            S_TX: begin
              if (scl_rise) cnt <= cnt + 1'b1;
              else if (scl_fall) begin
                if (cnt == CW'(DW)) begin
                  sda_oe <= 1'b0; st <= S_TACK;
                end else begin
                  tsr <= {tsr[DW-2:0], 1'b0}; sda_oe <= ~tsr[DW-2];
                end
              end
            end
            S_TACK: begin
              if (scl_rise) rxnak <= sda_s;
              else if (scl_fall) begin
                cnt <= '0;
                if (!rxnak) begin
                  tsr <= txh; tx_empty <= 1'b1; sda_oe <= ~txh[DW-1]; st <= S_TX;
                end else st <= S_IDLE;
              end
            end
            default: ;
          endcase
        end
        if (wr_tx) begin
          txh <= wr_data; tx_empty <= 1'b0;
        end
      end
    end
  end
endmodule

module i2c_slave_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_i,
  input logic sda_oe,
  input logic wr_tx,
  input logic rd_rx,
  input logic dir_rd,
  input logic rxnak,
  input logic tx_empty,
  input logic rx_full
);
  p_dis_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_oe && !dir_rd && rxnak && tx_empty && !rx_full));
  p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  p_txe_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(wr_tx));
  p_rxf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> ($past(rd_rx) || !$past(en)));
  p_nak_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rxnak) && $past(en)) |-> !sda_oe);
endmodule

bind i2c_slave_engine i2c_slave_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_i(scl_i), .sda_oe(sda_oe),
  .wr_tx(wr_tx), .rd_rx(rd_rx), .dir_rd(dir_rd), .rxnak(rxnak),
  .tx_empty(tx_empty), .rx_full(rx_full)
);

// File: tb/i2c_slave_engine_tb.sv
module i2c_slave_engine_tb;
  localparam logic [6:0] OWN = 7'h52;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wr_tx = 1'b0, rd_rx = 1'b0;
  logic [7:0] wr_data = '0;
  logic sda_oe, dir_rd, rxnak, tx_empty, rx_full;
  logic [7:0] rx_data;
  wire sda_bus = sda_m & ~sda_oe;
  int nchk = 0, nfail = 0;
  logic mon_on = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  i2c_slave_engine u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .own_addr(OWN), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .wr_tx(wr_tx), .wr_data(wr_data), .rd_rx(rd_rx), .rx_data(rx_data),
    .dir_rd(dir_rd), .rxnak(rxnak), .tx_empty(tx_empty), .rx_full(rx_full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic bstart; sda_m = 1; tick(10); scl_m = 1; tick(10); sda_m = 0; tick(10); scl_m = 0; tick(10); endtask
  task automatic bstop; sda_m = 0; tick(10); scl_m = 1; tick(10); sda_m = 1; tick(10); scl_m = 0; tick(10); endtask
  task automatic wbit(input logic b); sda_m = b; tick(10); scl_m = 1; tick(20); scl_m = 0; tick(10); endtask
  task automatic rbit(output logic b); sda_m = 1; tick(10); scl_m = 1; tick(10); b = sda_bus; tick(10); scl_m = 0; tick(10); endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(ack);
  endtask
  task automatic rbyte(output logic [7:0] d, input logic nak);
    logic b;
    for (int i = 0; i < 8; i++) begin rbit(b); d = {d[6:0], b}; end
    wbit(nak);
  endtask
  task automatic cpu_wr(input logic [7:0] d); wr_data = d; wr_tx = 1; tick(1); wr_tx = 0; tick(2); endtask
  task automatic send(input logic [7:0] d, input string tag);
    logic a;
    exp_q.push_back(d);
    wbyte(d, a);
    chk(tag, a, 0);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (mon_on && rx_full) begin
        if (exp_q.size() == 0) chk("R4 unexpected byte", rx_data, 32'hFFFF);
        else chk("R4 received byte", rx_data, exp_q.pop_front());
        rd_rx = 1; @(negedge clk); rd_rx = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    tick(4); rst_n = 1; tick(2);
    chk("R3 reset dir", dir_rd, 0);
    chk("R8 reset rxnak", rxnak, 1);
    chk("R6 reset tx_empty", tx_empty, 1);
    chk("R5 reset rx_full", rx_full, 0);
    chk("R9 reset sda_oe", sda_oe, 0);
    en = 1; tick(2);
    // R6 holding register reset value sent on a read
    bstart; wbyte({OWN, 1'b1}, a);
    chk("R2 read addr ack", a, 0);
    chk("R3 dir read", dir_rd, 1);
    chk("R7 tx_empty after addr load", tx_empty, 1);
    rbyte(d, 1);
    chk("R6 reset hold 0xFF", d, 8'hFF);
    chk("R8 nak seen", rxnak, 1);
    bstop;
    chk("R1 released after stop", sda_oe, 0);
    // R4 write stream through scoreboard
    mon_on = 1;
    bstart; wbyte({OWN, 1'b0}, a);
    chk("R2 write addr ack", a, 0);
    chk("R3 dir write", dir_rd, 0);
    send(8'h5A, "R4 ack b0"); send(8'hC3, "R4 ack b1"); send(8'h01, "R4 ack b2");
    tick(5); bstop;
    chk("R4 all bytes seen", exp_q.size(), 0);
    // R5 flag holds until read strobe
    mon_on = 0; tick(5);
    bstart; wbyte({OWN, 1'b0}, a); wbyte(8'h96, a); tick(50);
    chk("R5 rx_full set", rx_full, 1);
    chk("R4 rx_data", rx_data, 8'h96);
    rd_rx = 1; tick(1); rd_rx = 0; tick(2);
    chk("R5 rx_full cleared", rx_full, 0);
    bstop;
    // R2 mismatch
    bstart; wbyte({OWN ^ 7'h01, 1'b0}, a);
    chk("R2 mismatch no ack", a, 1);
    wbyte(8'h33, a);
    chk("R2 ignored after mismatch", a, 1);
    chk("R2 no capture after mismatch", rx_full, 0);
    bstop;
    // R7/R8 read chain
    cpu_wr(8'hA5);
    chk("R6 tx_empty cleared", tx_empty, 0);
    bstart; wbyte({OWN, 1'b1}, a);
    chk("R7 addr ack", a, 0);
    chk("R7 loaded on read match", tx_empty, 1);
    cpu_wr(8'h3C);
    rbyte(d, 0);
    chk("R7 byte A5", d, 8'hA5);
    chk("R8 ack seen", rxnak, 0);
    chk("R7 loaded after ack", tx_empty, 1);
    cpu_wr(8'h77);
    rbyte(d, 1);
    chk("R7 byte 3C", d, 8'h3C);
    chk("R8 nak flag", rxnak, 1);
    chk("R8 no load on nak", tx_empty, 0);
    chk("R8 released on nak", sda_oe, 0);
    rbit(a);
    chk("R8 line free after nak", a, 1);
    bstop;
    // R1 repeated start
    mon_on = 1;
    bstart; wbyte({OWN, 1'b0}, a);
    send(8'hE7, "R4 ack before restart");
    tick(5); mon_on = 0;
    bstart; wbyte({OWN, 1'b1}, a);
    chk("R1 restart addr ack", a, 0);
    chk("R3 dir after restart", dir_rd, 1);
    rbyte(d, 1);
    chk("R7 held byte after restart", d, 8'h77);
    bstop;
    // R1 bits after stop ignored
    wbyte({OWN, 1'b0}, a);
    chk("R1 no ack without start", a, 1);
    // R10 disable
    en = 0; tick(3);
    chk("R10 dir reset", dir_rd, 0);
    chk("R10 rxnak reset", rxnak, 1);
    chk("R10 tx_empty reset", tx_empty, 1);
    cpu_wr(8'h11);
    chk("R10 write ignored", tx_empty, 1);
    bstart; wbyte({OWN, 1'b0}, a);
    chk("R10 no ack disabled", a, 1);
    chk("R10 rx_full stays clear", rx_full, 0);
    bstop;
    en = 1; tick(3);
    bstart; wbyte({OWN, 1'b1}, a); rbyte(d, 1);
    chk("R10 hold back at 0xFF", d, 8'hFF);
    bstop;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule